// File: doc/BRIEF.md
# Hardware Thread Fork Allocator

The allocator serves the fork operation of a multithreaded core. The core holds a small pool of hardware thread contexts, and each context is bound to a virtual processing element. When a thread issues a fork, the allocator looks for a free context on the same processing element as the requester. It takes the lowest-indexed context that qualifies. It then gives that context a restart address and a value for one of its general registers, and marks the context as running with the requester's privilege mode and address-space ID.

The run-time status of every context is held in registers inside the block. This covers the activated, run-state, delay-slot, dirty, privilege and ASID fields, plus the restart PC. Three things come in from the surrounding control logic: which processing element each context is bound to, its dynamically-allocatable flag and its halt flag. A per-context deactivate pulse releases a context when its thread leaves.

A fork takes one clock. The block samples the request at a clock edge, and at that same edge it commits either the success write-back or the fault. A one-cycle done pulse marks the result.

If no context qualifies, the allocator writes code 1 into its exception-code register and pulses a thread fault.

Top module: `fork_alloc`

## Requirements
- R1: Only contexts with an index from 0 up to and including `cfg_ptc_i` are considered. A free context above that limit is never chosen.
- R2: When several contexts qualify, the one with the lowest index is chosen, and `win_o` reports that index together with the done pulse.
- R3: A context qualifies only when all four of these hold: its binding field `ctx_vpe_i[2*i +: 2]` equals `req_vpe_i`, `ctx_da_i[i]` is 1, `ctx_halt_i[i]` is 0, and its activated bit `ctx_act_o[i]` is 0.
- R4: On success, the chosen context's restart PC `ctx_rpc_o[32*i +: 32]` becomes `rs_i`. `gpr_we_o` pulses with `gpr_rd_o` equal to `rd_i` and `gpr_data_o` equal to `rt_i`, and `win_o` names the context being written.
- R5: On success, the chosen context gets run-state 2'b00, delay-slot 0, dirty 1 and activated 1. No other context changes through the fork.
- R6: On success, the chosen context's privilege field becomes `req_ksu_i` and its ASID field becomes `req_asid_i`.
- R7: When no context qualifies, `fault_o` pulses, `win_o` is 0, `excode_o` becomes 1 and no context state changes. A later successful fork leaves `excode_o` unchanged.
- R8: A request sampled at one clock edge gives a done pulse during the following cycle, with exactly one of `fault_o` and `gpr_we_o` high. With no request there is no done pulse.
- R9: A pulse on `act_clr_i[i]` clears context i's activated bit and sets its run-state to 2'b01. If a fork picks that same context in the same cycle, the fork's write wins.
- R10: After reset, every context has activated 0, run-state 2'b01, delay-slot 0, dirty 0, privilege 0, ASID 0 and restart PC 0. `excode_o` is 0 and done, fault and write strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_ptc_i | input | 3 | Highest context index to scan |
| ctx_vpe_i | input | 16 | Processing-element binding, 2 bits per context |
| ctx_da_i | input | 8 | Dynamically-allocatable flag per context |
| ctx_halt_i | input | 8 | Halt flag per context |
| act_clr_i | input | 8 | Deactivate pulse per context |
| fork_req_i | input | 1 | Fork request |
| req_vpe_i | input | 2 | Requester's processing element |
| rs_i | input | 32 | Restart address for the new thread |
| rt_i | input | 32 | Value for the destination register |
| rd_i | input | 5 | Destination register index |
| req_ksu_i | input | 2 | Requester's privilege mode |
| req_asid_i | input | 8 | Requester's address-space ID |
| done_o | output | 1 | Fork finished (one cycle) |
| fault_o | output | 1 | Thread fault: no free context |
| win_o | output | 3 | Chosen context index |
| gpr_we_o | output | 1 | Register write strobe into the chosen context |
| gpr_rd_o | output | 5 | Register index of that write |
| gpr_data_o | output | 32 | Data of that write |
| excode_o | output | 3 | Exception-code register |
| ctx_act_o | output | 8 | Activated bit per context |
| ctx_rnst_o | output | 16 | Run-state, 2 bits per context |
| ctx_tds_o | output | 8 | Delay-slot flag per context |
| ctx_dirty_o | output | 8 | Dirty flag per context |
| ctx_ksu_o | output | 16 | Privilege field, 2 bits per context |
| ctx_asid_o | output | 64 | ASID, 8 bits per context |
| ctx_rpc_o | output | 256 | Restart PC, 32 bits per context |

## Verification
The assertions watch the handshake shape on every cycle:
- each request yields one done pulse with exactly one outcome;
- a winner lies within the scan limit and was inactive just before;
- a fault always carries code 1;
- at most one context becomes active per cycle.

Whether the winner really is the lowest qualifying index, and whether the copied privilege, ASID, restart PC and register data are right, can only be shown by the bench. The bench compares against its own model across directed and random mixes of bindings, halt flags, allocatable flags and scan limits. That includes the same-cycle clash of a deactivate pulse and a fork.

// File: rtl/fork_alloc_pkg.sv
package fork_alloc_pkg;
  parameter int RNST_W = 2;
  parameter int KSU_W  = 2;
  parameter int ASID_W = 8;
  parameter int EXC_W  = 3;

  localparam logic [RNST_W-1:0] RNST_RUN     = '0;
  localparam logic [RNST_W-1:0] RNST_BLOCKED = RNST_W'(1);
  localparam logic [EXC_W-1:0]  EXC_NOFREE   = EXC_W'(1);

  typedef struct packed {
    logic              act;
    logic [RNST_W-1:0] rnst;
    logic              tds;
    logic              dirty;
    logic [KSU_W-1:0]  ksu;
    logic [ASID_W-1:0] asid;
  } ctx_stat_t;

  localparam ctx_stat_t STAT_RST = '{act: 1'b0, rnst: RNST_BLOCKED, tds: 1'b0,
                                     dirty: 1'b0, ksu: '0, asid: '0};
endpackage

// File: rtl/fork_elig.sv
module fork_elig #(
  parameter int NCTX  = 8,
  parameter int IDX_W = 3,
  parameter int VPE_W = 2
) (
  input  logic [IDX_W-1:0]      ptc_i,
  input  logic [VPE_W-1:0]      req_vpe_i,
  input  logic [NCTX*VPE_W-1:0] ctx_vpe_i,
  input  logic [NCTX-1:0]       da_i,
  input  logic [NCTX-1:0]       halt_i,
  input  logic [NCTX-1:0]       act_i,
  output logic [NCTX-1:0]       elig_o
);
  for (genvar g = 0; g < NCTX; g++) begin : g_el
    logic in_range;
    logic same_pe;
    assign in_range  = (IDX_W'(g) <= ptc_i);
    assign same_pe   = (ctx_vpe_i[g*VPE_W +: VPE_W] == req_vpe_i);
    assign elig_o[g] = in_range && same_pe && da_i[g] && !halt_i[g] && !act_i[g];
  end
endmodule

// File: rtl/fork_pick.sv
module fork_pick #(
  parameter int NCTX  = 8,
  parameter int IDX_W = 3
) (
  input  logic [NCTX-1:0]  elig_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  // lowest index wins: walk downward so the last hit is the lowest
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = NCTX - 1; i >= 0; i--) begin
      if (elig_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/fork_ctx_bank.sv
module fork_ctx_bank
  import fork_alloc_pkg::*;
#(
  parameter int NCTX  = 8,
  parameter int IDX_W = 3,
  parameter int XLEN  = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       load_i,
  input  logic [IDX_W-1:0]           sel_i,
  input  logic [XLEN-1:0]            rs_i,
  input  logic [KSU_W-1:0]           ksu_i,
  input  logic [ASID_W-1:0]          asid_i,
  input  logic [NCTX-1:0]            clr_i,
  output ctx_stat_t [NCTX-1:0]       stat_o,
  output logic [NCTX-1:0][XLEN-1:0]  rpc_o
);
  for (genvar g = 0; g < NCTX; g++) begin : g_ctx
    ctx_stat_t       stat_q;
    logic [XLEN-1:0] rpc_q;
    logic            wr;

    assign wr = load_i && (sel_i == IDX_W'(g));

    // fork write takes priority over a same-cycle deactivate
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stat_q <= STAT_RST;
        rpc_q  <= '0;
      end else if (wr) begin
        stat_q <= '{act: 1'b1, rnst: RNST_RUN, tds: 1'b0, dirty: 1'b1,
                    ksu: ksu_i, asid: asid_i};
        rpc_q  <= rs_i;
      end else if (clr_i[g]) begin
        stat_q.act  <= 1'b0;
        stat_q.rnst <= RNST_BLOCKED;
      end
    end

    assign stat_o[g] = stat_q;
    assign rpc_o[g]  = rpc_q;
  end
endmodule

// File: rtl/fork_alloc.sv
module fork_alloc
  import fork_alloc_pkg::*;
#(
  parameter int NCTX  = 8,
  parameter int VPE_W = 2,
  parameter int XLEN  = 32,
  parameter int RD_W  = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [((NCTX>1)?$clog2(NCTX):1)-1:0] cfg_ptc_i,
  input  logic [NCTX*VPE_W-1:0]    ctx_vpe_i,
  input  logic [NCTX-1:0]          ctx_da_i,
  input  logic [NCTX-1:0]          ctx_halt_i,
  input  logic [NCTX-1:0]          act_clr_i,
  input  logic                     fork_req_i,
  input  logic [VPE_W-1:0]         req_vpe_i,
  input  logic [XLEN-1:0]          rs_i,
  input  logic [XLEN-1:0]          rt_i,
  input  logic [RD_W-1:0]          rd_i,
  input  logic [KSU_W-1:0]         req_ksu_i,
  input  logic [ASID_W-1:0]        req_asid_i,
  output logic                     done_o,
  output logic                     fault_o,
  output logic [((NCTX>1)?$clog2(NCTX):1)-1:0] win_o,
  output logic                     gpr_we_o,
  output logic [RD_W-1:0]          gpr_rd_o,
  output logic [XLEN-1:0]          gpr_data_o,
  output logic [EXC_W-1:0]         excode_o,
  output logic [NCTX-1:0]          ctx_act_o,
  output logic [NCTX*RNST_W-1:0]   ctx_rnst_o,
  output logic [NCTX-1:0]          ctx_tds_o,
  output logic [NCTX-1:0]          ctx_dirty_o,
  output logic [NCTX*KSU_W-1:0]    ctx_ksu_o,
  output logic [NCTX*ASID_W-1:0]   ctx_asid_o,
  output logic [NCTX*XLEN-1:0]     ctx_rpc_o
);
  localparam int IDX_W = (NCTX > 1) ? $clog2(NCTX) : 1;

  ctx_stat_t [NCTX-1:0]      stat;
  logic [NCTX-1:0][XLEN-1:0] rpc;
  logic [NCTX-1:0]           act_vec;
  logic [NCTX-1:0]           elig;
  logic                      found;
  logic [IDX_W-1:0]          pick;
  logic                      load;

  for (genvar g = 0; g < NCTX; g++) begin : g_out
    assign act_vec[g]                         = stat[g].act;
    assign ctx_act_o[g]                       = stat[g].act;
    assign ctx_tds_o[g]                       = stat[g].tds;
    assign ctx_dirty_o[g]                     = stat[g].dirty;
    assign ctx_rnst_o[g*RNST_W +: RNST_W]     = stat[g].rnst;
    assign ctx_ksu_o[g*KSU_W +: KSU_W]        = stat[g].ksu;
    assign ctx_asid_o[g*ASID_W +: ASID_W]     = stat[g].asid;
    assign ctx_rpc_o[g*XLEN +: XLEN]          = rpc[g];
  end

  fork_elig #(.NCTX(NCTX), .IDX_W(IDX_W), .VPE_W(VPE_W)) u_elig (
    .ptc_i    (cfg_ptc_i),
    .req_vpe_i(req_vpe_i),
    .ctx_vpe_i(ctx_vpe_i),
    .da_i     (ctx_da_i),
    .halt_i   (ctx_halt_i),
    .act_i    (act_vec),
    .elig_o   (elig)
  );

  fork_pick #(.NCTX(NCTX), .IDX_W(IDX_W)) u_pick (
    .elig_i (elig),
    .found_o(found),
    .idx_o  (pick)
  );

  assign load = fork_req_i && found;

  fork_ctx_bank #(.NCTX(NCTX), .IDX_W(IDX_W), .XLEN(XLEN)) u_bank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .sel_i (pick),
    .rs_i  (rs_i),
    .ksu_i (req_ksu_i),
    .asid_i(req_asid_i),
    .clr_i (act_clr_i),
    .stat_o(stat),
    .rpc_o (rpc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o     <= 1'b0;
      fault_o    <= 1'b0;
      gpr_we_o   <= 1'b0;
      win_o      <= '0;
      gpr_rd_o   <= '0;
      gpr_data_o <= '0;
      excode_o   <= '0;
    end else begin
      done_o   <= fork_req_i;
      fault_o  <= fork_req_i && !found;
      gpr_we_o <= load;
      win_o    <= load ? pick : '0;
      if (load) begin
        gpr_rd_o   <= rd_i;
        gpr_data_o <= rt_i;
      end
      if (fork_req_i && !found) excode_o <= EXC_NOFREE;
    end
  end
endmodule

// File: rtl/fork_alloc_chk.sv
module fork_alloc_chk #(
  parameter int NCTX  = 8,
  parameter int EXC_W = 3
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     fork_req_i,
  input logic [((NCTX>1)?$clog2(NCTX):1)-1:0] cfg_ptc_i,
  input logic                     done_o,
  input logic                     fault_o,
  input logic                     gpr_we_o,
  input logic [((NCTX>1)?$clog2(NCTX):1)-1:0] win_o,
  input logic [EXC_W-1:0]         excode_o,
  input logic [NCTX-1:0]          ctx_act_o
);
  logic [NCTX-1:0] prev_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_act <= '0;
    else         prev_act <= ctx_act_o;
  end

  AST_DONE_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fork_req_i |=> done_o);  // R8
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fork_req_i |=> !done_o);  // R8
  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (fault_o != gpr_we_o));  // R8
  AST_WIN_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gpr_we_o |-> (win_o <= $past(cfg_ptc_i)));  // R1
  AST_WIN_WAS_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gpr_we_o |-> (!prev_act[win_o] && ctx_act_o[win_o]));  // R3
  AST_FAULT_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (excode_o == EXC_W'(1)));  // R7
  AST_ONE_NEW_ACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ctx_act_o & ~prev_act) <= 1);  // R5
endmodule

bind fork_alloc fork_alloc_chk #(.NCTX(NCTX), .EXC_W(fork_alloc_pkg::EXC_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .fork_req_i(fork_req_i),
  .cfg_ptc_i (cfg_ptc_i),
  .done_o    (done_o),
  .fault_o   (fault_o),
  .gpr_we_o  (gpr_we_o),
  .win_o     (win_o),
  .excode_o  (excode_o),
  .ctx_act_o (ctx_act_o)
);

// File: tb/sim_fork_alloc.sv
`timescale 1ns/1ps
module sim_fork_alloc;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_ptc = 3'd7;
  logic [15:0] ctx_vpe = '0;
  logic [7:0]  ctx_da = '1, ctx_halt = '0, act_clr = '0;
  logic        fork_req = 1'b0;
  logic [1:0]  req_vpe = '0, req_ksu = '0;
  logic [31:0] rs = '0, rt = '0;
  logic [4:0]  rd = '0;
  logic [7:0]  req_asid = '0;

  logic        done, fault, gpr_we;
  logic [2:0]  win, excode;
  logic [4:0]  gpr_rd;
  logic [31:0] gpr_data;
  logic [7:0]  act_o, tds_o, dirty_o;
  logic [15:0] rnst_o, ksu_o;
  logic [63:0] asid_o;
  logic [255:0] rpc_o;

  always #2 clk = ~clk;

  fork_alloc u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_ptc_i(cfg_ptc), .ctx_vpe_i(ctx_vpe),
    .ctx_da_i(ctx_da), .ctx_halt_i(ctx_halt), .act_clr_i(act_clr),
    .fork_req_i(fork_req), .req_vpe_i(req_vpe), .rs_i(rs), .rt_i(rt), .rd_i(rd),
    .req_ksu_i(req_ksu), .req_asid_i(req_asid), .done_o(done), .fault_o(fault),
    .win_o(win), .gpr_we_o(gpr_we), .gpr_rd_o(gpr_rd), .gpr_data_o(gpr_data),
    .excode_o(excode), .ctx_act_o(act_o), .ctx_rnst_o(rnst_o), .ctx_tds_o(tds_o),
    .ctx_dirty_o(dirty_o), .ctx_ksu_o(ksu_o), .ctx_asid_o(asid_o), .ctx_rpc_o(rpc_o)
  );

  int total = 0, bad = 0;

  // bench model of context state
  logic        m_act[N];
  logic [1:0]  m_rnst[N];
  logic        m_dirty[N];
  logic [1:0]  m_ksu[N];
  logic [7:0]  m_asid[N];
  logic [31:0] m_rpc[N];
  logic [2:0]  m_exc;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int model_pick(input logic [1:0] vpe);
    for (int i = 0; i <= int'(cfg_ptc); i++)
      if (ctx_vpe[i*2 +: 2] == vpe && ctx_da[i] && !ctx_halt[i] && !m_act[i]) return i;
    return -1;
  endfunction

  task automatic chk_state(input string req);
    logic [7:0] ea, ed; logic [15:0] er, ek; logic [63:0] es; logic [255:0] ep;
    for (int i = 0; i < N; i++) begin
      ea[i] = m_act[i]; ed[i] = m_dirty[i]; er[i*2 +: 2] = m_rnst[i];
      ek[i*2 +: 2] = m_ksu[i]; es[i*8 +: 8] = m_asid[i]; ep[i*32 +: 32] = m_rpc[i];
    end
    check(act_o == ea, req, "act", 256'(act_o), 256'(ea));
    check(rnst_o == er, req, "rnst", 256'(rnst_o), 256'(er));
    check(tds_o == 8'h0, req, "tds", 256'(tds_o), 256'(0));
    check(dirty_o == ed, req, "dirty", 256'(dirty_o), 256'(ed));
    check(ksu_o == ek, req, "ksu", 256'(ksu_o), 256'(ek));
    check(asid_o == es, req, "asid", 256'(asid_o), 256'(es));
    check(rpc_o == ep, req, "rpc", rpc_o, ep);
    check(excode == m_exc, req, "excode", 256'(excode), 256'(m_exc));
  endtask

  // called at a negedge; returns at the next negedge with outputs checked
  task automatic do_fork(input logic [1:0] vpe, input logic [7:0] cmask,
                         input int exp_w, input string req);
    int w;
    w = model_pick(vpe);
    req_vpe = vpe; rs = $urandom; rt = $urandom; rd = 5'($urandom);
    req_ksu = 2'($urandom); req_asid = 8'($urandom);
    act_clr = cmask; fork_req = 1'b1;
    @(posedge clk); @(negedge clk);
    fork_req = 1'b0; act_clr = '0;
    for (int i = 0; i < N; i++)
      if (cmask[i] && i != w) begin m_act[i] = 1'b0; m_rnst[i] = 2'b01; end
    if (w >= 0) begin
      m_act[w] = 1'b1; m_rnst[w] = 2'b00; m_dirty[w] = 1'b1;
      m_ksu[w] = req_ksu; m_asid[w] = req_asid; m_rpc[w] = rs;
    end else m_exc = 3'd1;
    if (exp_w != -2) check(w == exp_w, req, "directed pick", 256'(w), 256'(exp_w));
    check(done == 1'b1, "R8", "done", 256'(done), 256'(1));
    check(fault == (w < 0), req, "fault", 256'(fault), 256'(w < 0));
    check(gpr_we == (w >= 0), req, "gpr_we", 256'(gpr_we), 256'(w >= 0));
    check(int'(win) == ((w < 0) ? 0 : w), req, "win", 256'(win), 256'((w < 0) ? 0 : w));
    if (w >= 0) begin
      check(gpr_rd == rd, "R4", "gpr_rd", 256'(gpr_rd), 256'(rd));
      check(gpr_data == rt, "R4", "gpr_data", 256'(gpr_data), 256'(rt));
    end
    chk_state(req);
  endtask

  task automatic do_clr(input logic [7:0] mask, input string req);
    act_clr = mask;
    @(posedge clk); @(negedge clk);
    act_clr = '0;
    for (int i = 0; i < N; i++)
      if (mask[i]) begin m_act[i] = 1'b0; m_rnst[i] = 2'b01; end
    check(done == 1'b0, "R8", "done idle", 256'(done), 256'(0));
    chk_state(req);
  endtask

  initial begin
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < N; i++) begin
      m_act[i] = 0; m_rnst[i] = 2'b01; m_dirty[i] = 0;
      m_ksu[i] = 0; m_asid[i] = 0; m_rpc[i] = 0;
    end
    m_exc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(done == 0 && fault == 0 && gpr_we == 0, "R10", "strobes", 256'({done, fault, gpr_we}), 256'(0));
    chk_state("R10");

    // R2 R4 R5 R6 lowest index first
    do_fork(2'd0, 8'h00, 0, "R2");
    do_fork(2'd0, 8'h00, 1, "R6");
    // R3 halt, allocatable and binding each exclude
    ctx_halt[2] = 1'b1; ctx_da[3] = 1'b0; ctx_vpe[4*2 +: 2] = 2'd1;
    do_fork(2'd0, 8'h00, 5, "R3");
    // R1 free contexts 6,7 above the limit are skipped, R7 fault
    cfg_ptc = 3'd5;
    do_fork(2'd0, 8'h00, -1, "R1");
    check(excode == 3'd1, "R7", "excode after fault", 256'(excode), 256'(1));
    cfg_ptc = 3'd7;
    do_fork(2'd0, 8'h00, 6, "R1");
    do_fork(2'd0, 8'h00, 7, "R7");
    check(excode == 3'd1, "R7", "excode kept on success", 256'(excode), 256'(1));
    do_fork(2'd0, 8'h00, -1, "R7");
    do_fork(2'd1, 8'h00, 4, "R3");
    // R9 deactivate then refork
    do_clr(8'h02, "R9");
    do_fork(2'd0, 8'h00, 1, "R9");
    // R9 clear in same cycle does not free for that fork
    do_fork(2'd0, 8'h01, -1, "R9");
    do_fork(2'd0, 8'h00, 0, "R9");
    // R9 fork beats clear on the winner
    do_clr(8'h02, "R9");
    do_fork(2'd0, 8'h02, 1, "R9");

    // random mix
    ctx_halt = '0; ctx_da = '1;
    for (int it = 0; it < 400; it++) begin
      if (it % 16 == 0) begin
        cfg_ptc = 3'($urandom);
        ctx_vpe = 16'($urandom) & 16'h5555;
        ctx_halt = 8'($urandom) & 8'($urandom);
        ctx_da = 8'($urandom) | 8'($urandom);
      end
      if ($urandom % 3 == 0) do_clr(8'($urandom) & 8'($urandom), "R9");
      else do_fork(2'($urandom % 2), ($urandom % 4 == 0) ? 8'($urandom) : 8'h00, -2, "R2");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule